// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the serial bit clock and the per-direction frame (word-select) clocks for a stereo audio serial port. All of its logic runs on one clock. In master mode that clock is the audio master clock: a bit divider derives the bit clock from it, and two frame counters derive the transmit and receive frame clocks from the bit clock. In slave mode the bit clock and the frame clocks come in on pins. The block brings them into its clock domain and finds their edges there.

The serializers do not watch the clocks directly. They receive one-cycle strobes instead: a launch strobe where data should change, a sample strobe where data should be captured, and a frame-start pulse for each direction. Software fields set the following:
- the bit divider
- a separate frame length for transmit and for receive
- the bit-clock and frame-clock pin polarities, independently
- whether receive reuses the transmit clocks

A new divider setting is applied only at a frame boundary, so a reprogram never shortens a bit period or a frame.

Top module: `aud_clkgen`

## Requirements
- R1: While `rst_n` is low, both strobes and both frame-start pulses are 0. In master mode `bclk_out` equals `cfg_bclk_inv`, and both frame clocks equal `cfg_fclk_inv`.
- R2: In master mode, with bit divider B, the logical bit clock has a period of B cycles. It is low for floor(B/2) cycles and high for the rest, so the duty is 50% when B is even. It starts low in the cycle after the first clock edge with reset released.
- R3: `bclk_launch` is a one-cycle pulse in the first cycle the logical bit clock is low, and `bclk_sample` is a one-cycle pulse in the first cycle it is high. The two are never high together, and neither depends on the polarity settings.
- R4: In master mode, with frame length F bit periods, a direction's logical frame clock is low for the first floor(F/2) bit periods of each frame and high for the rest. It changes only in cycles where `bclk_launch` is high.
- R5: In master mode, `tx_fstart` (or `rx_fstart`) is a one-cycle pulse together with the launch strobe that begins each new frame of that direction after the first.
- R6: Any divider or frame-length field below 2 is treated as 2.
- R7: A new bit divider or transmit frame length takes effect at the next transmit frame boundary. A new receive frame length takes effect at the next receive frame boundary. The frame in progress finishes with the old values.
- R8: With `cfg_rx_share` = 0, receive uses its own frame length and pin. With `cfg_rx_share` = 1, `rx_fclk` and `rx_fstart` equal `tx_fclk` and `tx_fstart`.
- R9: Pin level equals logical level XOR polarity bit: `bclk_out` uses `cfg_bclk_inv`, and the frame clocks use `cfg_fclk_inv`. Logical bit clock 0 is the launch phase, and logical frame clock 0 is the first half of the frame.
- R10: In slave mode (`cfg_master` = 0), each clock pin passes through a two-stage synchroniser. The clock outputs repeat the pin level two cycles after the change. The strobes and frame-start pulses mark edges of the logical (polarity-corrected) synchronised levels, and appear in the cycle after the second synchroniser edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master audio clock, the only clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate clocks, 0: take clocks from pins |
| cfg_bdiv | input | BDW | master clocks per bit clock |
| cfg_tx_fdiv | input | FDW | bit clocks per transmit frame |
| cfg_rx_fdiv | input | FDW | bit clocks per receive frame |
| cfg_rx_share | input | 1 | receive reuses the transmit frame clock |
| cfg_bclk_inv | input | 1 | invert bit-clock pin polarity |
| cfg_fclk_inv | input | 1 | invert frame-clock pin polarity |
| ext_bclk | input | 1 | bit clock pin in slave mode |
| ext_tx_fclk | input | 1 | transmit frame clock pin in slave mode |
| ext_rx_fclk | input | 1 | receive frame clock pin in slave mode |
| bclk_out | output | 1 | bit clock at pin level |
| bclk_launch | output | 1 | data-change strobe |
| bclk_sample | output | 1 | data-capture strobe |
| tx_fclk | output | 1 | transmit frame clock at pin level |
| tx_fstart | output | 1 | transmit frame start pulse |
| rx_fclk | output | 1 | receive frame clock at pin level |
| rx_fstart | output | 1 | receive frame start pulse |

## Verification
A frame wrap falls in the same cycle as the reload of the divider settings. Both land on the bit-counter terminal count that raises the launch strobe. The bench provokes this by rewriting the bit divider and both frame lengths in the middle of a frame. It then checks, cycle by cycle, that every launch strobe and frame-start pulse keeps the old spacing up to the wrap, and takes the new spacing from the cycle after it. The receive and transmit wraps also coincide in the sweep whenever their lengths share a factor. The bench checks that the receive pulse follows its own length in that cycle, and follows the transmit one when shared.

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
  parameter int BDW = 8,
  parameter int FDW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_master,
  input  logic [BDW-1:0] cfg_bdiv,
  input  logic [FDW-1:0] cfg_tx_fdiv,
  input  logic [FDW-1:0] cfg_rx_fdiv,
  input  logic           cfg_rx_share,
  input  logic           cfg_bclk_inv,
  input  logic           cfg_fclk_inv,
  input  logic           ext_bclk,
  input  logic           ext_tx_fclk,
  input  logic           ext_rx_fclk,
  output logic           bclk_out,
  output logic           bclk_launch,
  output logic           bclk_sample,
  output logic           tx_fclk,
  output logic           tx_fstart,
  output logic           rx_fclk,
  output logic           rx_fstart
);
  localparam logic [BDW-1:0] B_MIN = BDW'(2);
  localparam logic [FDW-1:0] F_MIN = FDW'(2);

  logic           armed;
  logic [BDW-1:0] b_act, bcnt;
  logic [FDW-1:0] tf_act, rf_act, tcnt, rcnt;
  logic           bclk_i, launch_m, sample_m;
  logic           tfclk_i, rfclk_i, tstart_m, rstart_m;
  logic [2:0]     sb, st, sr;

  wire [BDW-1:0] b_req  = (cfg_bdiv < B_MIN) ? B_MIN : cfg_bdiv;
  wire [FDW-1:0] tf_req = (cfg_tx_fdiv < F_MIN) ? F_MIN : cfg_tx_fdiv;
  wire [FDW-1:0] rf_req = (cfg_rx_fdiv < F_MIN) ? F_MIN : cfg_rx_fdiv;

  wire [BDW-1:0] b_half = b_act >> 1;
  wire tick   = armed && (bcnt == b_act - 1'b1);
  wire rise   = armed && (bcnt == b_half - 1'b1);
  wire t_wrap = tick && (tcnt == tf_act - 1'b1);
  wire r_wrap = tick && (rcnt == rf_act - 1'b1);

  // master path: bit divider and two frame counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      b_act    <= '0;
      tf_act   <= '0;
      rf_act   <= '0;
      bcnt     <= '0;
      tcnt     <= '0;
      rcnt     <= '0;
      bclk_i   <= 1'b0;
      launch_m <= 1'b0;
      sample_m <= 1'b0;
      tfclk_i  <= 1'b0;
      rfclk_i  <= 1'b0;
      tstart_m <= 1'b0;
      rstart_m <= 1'b0;
    end else if (!armed) begin
      armed  <= 1'b1;
      b_act  <= b_req;
      tf_act <= tf_req;
      rf_act <= rf_req;
    end else begin
      bcnt     <= tick ? '0 : bcnt + 1'b1;
      launch_m <= tick;
      sample_m <= rise;
      tstart_m <= t_wrap;
      rstart_m <= r_wrap;
      if (tick)      bclk_i <= 1'b0;
      else if (rise) bclk_i <= 1'b1;
      if (tick) begin
        tcnt    <= t_wrap ? '0 : tcnt + 1'b1;
        rcnt    <= r_wrap ? '0 : rcnt + 1'b1;
        tfclk_i <= t_wrap ? 1'b0 : ((tcnt + 1'b1) >= (tf_act >> 1));
        rfclk_i <= r_wrap ? 1'b0 : ((rcnt + 1'b1) >= (rf_act >> 1));
      end
      if (t_wrap) begin
        b_act  <= b_req;
        tf_act <= tf_req;
      end
      if (r_wrap) rf_act <= rf_req;
    end
  end

  // slave path: two-stage synchronisers plus one history stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb <= '0;
      st <= '0;
      sr <= '0;
    end else begin
      sb <= {sb[1:0], ext_bclk};
      st <= {st[1:0], ext_tx_fclk};
      sr <= {sr[1:0], ext_rx_fclk};
    end
  end

  wire lb_now = sb[1] ^ cfg_bclk_inv;
  wire lb_old = sb[2] ^ cfg_bclk_inv;
  wire lt_now = st[1] ^ cfg_fclk_inv;
  wire lt_old = st[2] ^ cfg_fclk_inv;
  wire lr_now = sr[1] ^ cfg_fclk_inv;
  wire lr_old = sr[2] ^ cfg_fclk_inv;

  wire txf  = cfg_master ? (tfclk_i ^ cfg_fclk_inv) : st[1];
  wire txs  = cfg_master ? tstart_m : (lt_old & ~lt_now);
  wire rxf  = cfg_master ? (rfclk_i ^ cfg_fclk_inv) : sr[1];
  wire rxs  = cfg_master ? rstart_m : (lr_old & ~lr_now);

  assign bclk_out    = cfg_master ? (bclk_i ^ cfg_bclk_inv) : sb[1];
  assign bclk_launch = cfg_master ? launch_m : (lb_old & ~lb_now);
  assign bclk_sample = cfg_master ? sample_m : (~lb_old & lb_now);
  assign tx_fclk     = txf;
  assign tx_fstart   = txs;
  assign rx_fclk     = cfg_rx_share ? txf : rxf;
  assign rx_fstart   = cfg_rx_share ? txs : rxs;
endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_bclk_inv,
  input logic cfg_fclk_inv,
  input logic bclk_out,
  input logic bclk_launch,
  input logic bclk_sample,
  input logic tx_fclk,
  input logic tx_fstart,
  input logic rx_fclk,
  input logic rx_fstart
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_launch && bclk_sample));

  assert_launch_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_launch |-> ((bclk_out ^ cfg_bclk_inv) == 1'b0));

  assert_sample_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_sample |-> ((bclk_out ^ cfg_bclk_inv) == 1'b1));

  assert_tx_start_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fstart |-> ((tx_fclk ^ cfg_fclk_inv) == 1'b0));

  assert_rx_start_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fstart |-> ((rx_fclk ^ cfg_fclk_inv) == 1'b0));

  assert_tx_start_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && tx_fstart) |-> bclk_launch);

  assert_bclk_moves_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $stable(cfg_master) && $stable(cfg_bclk_inv) && !$stable(bclk_out))
      |-> (bclk_launch || bclk_sample));

  assert_fclk_moves_on_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $stable(cfg_master) && $stable(cfg_fclk_inv) && !$stable(tx_fclk))
      |-> bclk_launch);
endmodule

bind aud_clkgen aud_clkgen_chk u_chk (.*);

// File: tb/aud_clkgen_bench.sv
module aud_clkgen_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1;
  logic [7:0] cfg_bdiv = 8'd2;
  logic [8:0] cfg_tx_fdiv = 9'd4;
  logic [8:0] cfg_rx_fdiv = 9'd4;
  logic cfg_rx_share = 1'b0;
  logic cfg_bclk_inv = 1'b0;
  logic cfg_fclk_inv = 1'b0;
  logic ext_bclk = 1'b0;
  logic ext_tx_fclk = 1'b0;
  logic ext_rx_fclk = 1'b0;
  logic bclk_out, bclk_launch, bclk_sample, tx_fclk, tx_fstart, rx_fclk, rx_fstart;

  int n_run = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  aud_clkgen u_aud_clkgen (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 launch", bclk_launch, 0);
    chk("R1 sample", bclk_sample, 0);
    chk("R1 tx_fstart", tx_fstart, 0);
    chk("R1 rx_fstart", rx_fstart, 0);
    if (cfg_master) begin
      chk("R1 bclk", bclk_out, cfg_bclk_inv);
      chk("R1 tx_fclk", tx_fclk, cfg_fclk_inv);
      chk("R1 rx_fclk", rx_fclk, cfg_fclk_inv);
    end
  endtask

  task automatic run_master(input int bd, input int tf, input int rf,
                            input bit sh, input bit bi, input bit fi);
    int b, ft, fr, h, n;
    string bt;
    cfg_master = 1'b1; cfg_bdiv = 8'(bd); cfg_tx_fdiv = 9'(tf); cfg_rx_fdiv = 9'(rf);
    cfg_rx_share = sh; cfg_bclk_inv = bi; cfg_fclk_inv = fi;
    hold_reset();
    rst_n = 1'b1;
    b  = (bd < 2) ? 2 : bd;
    ft = (tf < 2) ? 2 : tf;
    fr = (rf < 2) ? 2 : rf;
    h  = b / 2;
    n  = 2 * b * ((ft > fr) ? ft : fr) + b;
    bt = (bd < 2) ? "R6/R2/R9 bclk" : "R2/R9 bclk";
    for (int c = 0; c <= n; c++) begin
      int ph, k;
      bit tk, tl, rl, ts, rs;
      @(posedge clk);
      @(negedge clk);
      ph = (c + b - 1) % b;
      tk = (c >= 1) && (c % b == 0);
      k  = c / b;
      tl = (k % ft) >= ft / 2;
      ts = tk && (k % ft == 0) && (k > 0);
      rl = sh ? tl : ((k % fr) >= fr / 2);
      rs = sh ? ts : (tk && (k % fr == 0) && (k > 0));
      chk(bt, bclk_out, int'((c >= 1 && ph >= h - 1 && ph <= b - 2) ^ bi));
      chk("R3 launch", bclk_launch, tk);
      chk("R3 sample", bclk_sample, int'(c >= 1 && ph == h - 1));
      chk((tf < 2) ? "R6/R4/R9 tx_fclk" : "R4/R9 tx_fclk", tx_fclk, int'(tl ^ fi));
      chk("R5 tx_fstart", tx_fstart, ts);
      chk("R8/R4 rx_fclk", rx_fclk, int'(rl ^ fi));
      chk("R8/R5 rx_fstart", rx_fstart, rs);
    end
  endtask

  task automatic run_reload();
    cfg_master = 1'b1; cfg_bdiv = 8'd2; cfg_tx_fdiv = 9'd4; cfg_rx_fdiv = 9'd4;
    cfg_rx_share = 1'b0; cfg_bclk_inv = 1'b0; cfg_fclk_inv = 1'b0;
    hold_reset();
    rst_n = 1'b1;
    for (int c = 0; c <= 80; c++) begin
      bit el;
      @(posedge clk);
      @(negedge clk);
      el = (c <= 8) ? (c >= 1 && c % 2 == 0) : ((c - 8) % 4 == 0);
      chk("R7 launch", bclk_launch, el);
      chk("R7 tx_fstart", tx_fstart, int'(c == 8 || c == 40 || c == 72));
      chk("R7 rx_fstart", rx_fstart, int'(c >= 8 && c % 8 == 0));
      if (c == 3) begin
        cfg_bdiv = 8'd4; cfg_tx_fdiv = 9'd8; cfg_rx_fdiv = 9'd2;
      end
    end
  endtask

  task automatic sl_step(input bit eb, input bit et, input bit er,
                         input int el, input int es, input int ets, input int ers,
                         input string tag);
    ext_bclk = eb; ext_tx_fclk = et; ext_rx_fclk = er;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({tag, " launch"}, bclk_launch, el);
    chk({tag, " sample"}, bclk_sample, es);
    chk({tag, " tx_fstart"}, tx_fstart, ets);
    chk({tag, " rx_fstart"}, rx_fstart, ers);
    chk({tag, " bclk pin"}, bclk_out, eb);
    chk({tag, " tx pin"}, tx_fclk, et);
    chk({tag, " rx pin"}, rx_fclk, cfg_rx_share ? et : er);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " strobes clear"}, int'(bclk_launch | bclk_sample | tx_fstart | rx_fstart), 0);
  endtask

  task automatic run_slave();
    ext_bclk = 1'b0; ext_tx_fclk = 1'b0; ext_rx_fclk = 1'b0;
    cfg_master = 1'b0; cfg_rx_share = 1'b0; cfg_bclk_inv = 1'b0; cfg_fclk_inv = 1'b0;
    hold_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    sl_step(1, 0, 0, 0, 1, 0, 0, "R10 bclk rise");
    sl_step(0, 0, 0, 1, 0, 0, 0, "R10 bclk fall");
    sl_step(0, 1, 0, 0, 0, 0, 0, "R10 tx rise");
    sl_step(0, 0, 0, 0, 0, 1, 0, "R10 tx fall");
    sl_step(0, 0, 1, 0, 0, 0, 0, "R10/R8 rx rise");
    sl_step(0, 0, 0, 0, 0, 0, 1, "R10/R8 rx fall");
    ext_bclk = 1'b0; ext_tx_fclk = 1'b0; ext_rx_fclk = 1'b0;
    cfg_rx_share = 1'b1; cfg_bclk_inv = 1'b1; cfg_fclk_inv = 1'b1;
    hold_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    sl_step(1, 0, 0, 1, 0, 0, 0, "R10/R9 inv bclk rise");
    sl_step(0, 0, 0, 0, 1, 0, 0, "R10/R9 inv bclk fall");
    sl_step(0, 1, 0, 0, 0, 1, 1, "R10/R8 shared tx rise");
    sl_step(0, 0, 1, 0, 0, 0, 0, "R10/R8 shared rx ignored");
  endtask

  initial begin
    #(PERIOD * 190000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int tfs[4] = '{1, 2, 3, 6};
    int rfs[2] = '{2, 5};
    for (int bd = 1; bd <= 5; bd++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 2; j++)
          for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++)
              run_master(bd, tfs[i], rfs[j], s[0], p[0], p[1]);
    run_reload();
    run_slave();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule